// File: doc/BRIEF.md
# Transmit Checksum Offload Header Parser

This block takes a frame held in its own byte store. The frame starts with an 8-byte control block written by the host. The host loads the frame one byte at a time, then pulses `start` with the frame length. The block reads the control block to learn which checksum work is wanted and where the network and transport headers sit. It fills in or clears the requested checksum fields in place. It then streams the frame without the control block, one byte per clock.

Header positions are never found by parsing the packet. They come from two offsets in the control block. Byte 3 gives the IPv4 header start, counted from the first byte after the control block. Byte 2 gives the transport header start, counted from the IPv4 header start. Byte 0 carries the flags. A UDP datagram whose checksum is not requested has its checksum field forced to zero. When a checksum is requested, the block computes it over the IPv4 pseudo-header and the segment.

Top module: `tcb_offload_top`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `out_valid` and `out_last` are low.
- R2: For a frame of length L > 8, the block emits bytes 8 to L-1 of the (possibly updated) frame in order. It emits one byte on every consecutive cycle and raises `out_last` with byte L-1 only. `busy` is low from the cycle that carries `out_last`.
- R3: A frame of length L <= 8 produces no output bytes, and the block returns to idle.
- R4: When flag bit 7 (IPv4) and flag bit 5 (IP checksum) of byte 0 are both set, the block works on the IPv4 header at H = 8 + byte3. The header length is 4 times the low nibble of byte H. Header bytes H+10 and H+11 count as zero when summing. The block writes there the inverted ones-complement sum of the header's big-endian 16-bit words, high byte at H+10.
- R5: When flag bit 7 is clear, the frame is sent unchanged whatever the other flag bits hold. Transport handling needs both bit 7 and bit 3 (TCP/UDP present).
- R6: With bits 7, 3 and 6 (UDP) set and bit 4 (transport checksum) clear, bytes T+6 and T+7 are written to zero, where T = H + byte2.
- R7: With bits 7, 3 and 4 set, the block computes the transport checksum and writes it big-endian at T+6 for UDP or T+16 for TCP. The checksum is the inverted ones-complement sum of the source and destination addresses (bytes H+12..H+19), the protocol byte H+9, the segment length L-T, and the segment from T to L-1 with the checksum field counted as zero.
- R8: A UDP checksum that computes to 0x0000 is written as 0xFFFF. A TCP checksum is written as computed.
- R9: When the segment length is odd, the last segment byte is summed as the high byte of a word whose low byte is zero.
- R10: Let the start strobe be sampled at edge t0, and let D = 3, plus 2 + 2*IHL when R4 applies, plus 1 when R6 applies, plus 6 + ceil((L-T)/2) when R7 applies. Byte 8 is then valid in the cycle after edge t0 + D.
- R11: While `busy` is high, both `start` and load writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one byte into the frame store |
| ld_addr | input | AW (8) | Byte address of the load |
| ld_data | input | 8 | Byte to load |
| start | input | 1 | Begin processing the stored frame |
| frame_len | input | LW (9) | Frame length in bytes, control block included |
| busy | output | 1 | Frame being processed or sent |
| out_valid | output | 1 | `out_data` holds a frame byte |
| out_data | output | 8 | Output byte stream |
| out_last | output | 1 | Final byte of the frame |

## Verification
The first output byte is due a fixed number of cycles after the start edge. That number depends only on which checksum jobs the flags select, the IPv4 header length and the segment length (the D of R10). The bench works out D from the frame it built. It then expects `out_valid` low on every cycle before t0 + D + 1 and exactly one byte per cycle for L-8 cycles after that. It compares at the falling edge of each cycle, so any gap, early or late byte, or misplaced `out_last` is caught on the exact cycle it happens. A load write and a second start are injected while the block is sending, and the later output bytes show whether either one was acted on.

// File: rtl/tcb_offload_pkg.sv
package tcb_offload_pkg;

   localparam int CB_BYTES     = 8;
   // control block byte positions read by the sequencer
   localparam int CB_L4OFF_POS = 2;
   localparam int CB_L3OFF_POS = 3;
   // flag bits of control block byte 0
   localparam int FL_IPV4      = 7;
   localparam int FL_UDP       = 6;
   localparam int FL_IPCK      = 5;
   localparam int FL_L4CK      = 4;
   localparam int FL_L4        = 3;
   // IPv4 header field positions
   localparam int IP_PROTO_POS = 9;
   localparam int IP_CSUM_POS  = 10;
   localparam int IP_SRC_POS   = 12;
   // transport checksum field positions
   localparam int UDP_CSUM_POS = 6;
   localparam int TCP_CSUM_POS = 16;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DECODE,
      ST_IPSUM,
      ST_IPWR,
      ST_L4SEL,
      ST_ZERO,
      ST_PSEUDO,
      ST_L4SUM,
      ST_L4WR,
      ST_SEND
   } tcb_state_e;

   // ones-complement addition with end-around carry
   function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction

endpackage

// File: rtl/tcb_frame_store.sv
module tcb_frame_store #(
   parameter int DEPTH = 256,
   parameter int AW    = 8,
   parameter int NRP   = 3
) (
   input  logic                    clk,
   input  logic                    bw_en,
   input  logic [AW-1:0]           bw_addr,
   input  logic [7:0]              bw_data,
   input  logic                    ww_en,
   input  logic [AW-1:0]           ww_addr,
   input  logic [15:0]             ww_data,
   input  logic [NRP-1:0][AW-1:0]  rd_addr,
   output logic [NRP-1:0][7:0]     rd_data
);

   logic [7:0] mem_q [DEPTH];

   // word write from the sequencer wins over a byte load
   always_ff @(posedge clk) begin
      if (ww_en) begin
         mem_q[ww_addr]          <= ww_data[15:8];
         mem_q[ww_addr + AW'(1)] <= ww_data[7:0];
      end else if (bw_en) begin
         mem_q[bw_addr] <= bw_data;
      end
   end

   for (genvar g = 0; g < NRP; g++) begin : g_rd
      assign rd_data[g] = mem_q[rd_addr[g]];
   end

endmodule

// File: rtl/tcb_csum_acc.sv
module tcb_csum_acc
   import tcb_offload_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [15:0] load_val,
   input  logic        add,
   input  logic [15:0] word,
   output logic [15:0] acc
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (load) begin
         acc <= load_val;
      end else if (add) begin
         acc <= oc_add(acc, word);
      end
   end

endmodule

// File: rtl/tcb_offload_top.sv
module tcb_offload_top
   import tcb_offload_pkg::*;
#(
   parameter int MAX_LEN = 256,
   parameter int AW      = $clog2(MAX_LEN),
   parameter int LW      = $clog2(MAX_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_addr,
   input  logic [7:0]    ld_data,
   input  logic          start,
   input  logic [LW-1:0] frame_len,
   output logic          busy,
   output logic          out_valid,
   output logic [7:0]    out_data,
   output logic          out_last
);

   localparam int IW  = AW + 2;
   localparam int NRP = 3;

   if (MAX_LEN < 64 || MAX_LEN > 16384) begin : g_len_range_chk
      $error("MAX_LEN must lie in 64..16384");
   end
   if ((MAX_LEN & (MAX_LEN - 1)) != 0) begin : g_len_pow2_chk
      $error("MAX_LEN must be a power of two");
   end
   if (AW != $clog2(MAX_LEN) || LW != $clog2(MAX_LEN + 1)) begin : g_width_chk
      $error("AW and LW must follow MAX_LEN");
   end

   tcb_state_e state_q;
   logic [LW-1:0] len_q;
   logic          fl_ip_q, fl_udp_q, fl_l4ck_q, fl_l4_q;
   logic [IW-1:0] l3s_q, l4s_q, ptr_q;
   logic [1:0]    k_q;

   logic [NRP-1:0][AW-1:0] rd_addr;
   logic [NRP-1:0][7:0]    rd_d;
   logic [IW-1:0]          a_w [NRP];

   logic          ww_en;
   logic [IW-1:0] ww_addr_w;
   logic [15:0]   ww_data;

   logic          acc_load, acc_add;
   logic [15:0]   acc_init, acc_word, acc;

   logic [IW-1:0] len_i, ip_end, l4len, ck_addr, psd_addr, last_idx;
   logic [15:0]   rd_word, ip_res, l4_res;

   assign len_i    = IW'(len_q);
   assign last_idx = len_i - IW'(1);
   assign ip_end   = l3s_q + IW'({rd_d[2][3:0], 2'b00});
   assign l4len    = len_i - l4s_q;
   assign ck_addr  = l4s_q + (fl_udp_q ? IW'(UDP_CSUM_POS) : IW'(TCP_CSUM_POS));
   assign psd_addr = l3s_q + IW'(IP_SRC_POS) + IW'({k_q, 1'b0});
   assign rd_word  = {rd_d[0], rd_d[1]};
   assign ip_res   = ~acc;
   assign l4_res   = (fl_udp_q && (acc == 16'hFFFF)) ? 16'hFFFF : ~acc;
   assign busy     = (state_q != ST_IDLE);

   // read address selection per state
   always_comb begin
      for (int i = 0; i < NRP; i++) a_w[i] = '0;
      case (state_q)
         ST_DECODE: begin
            a_w[0] = '0;
            a_w[1] = IW'(CB_L3OFF_POS);
            a_w[2] = IW'(CB_L4OFF_POS);
         end
         ST_IPSUM: begin
            a_w[0] = ptr_q;
            a_w[1] = ptr_q + IW'(1);
            a_w[2] = l3s_q;
         end
         ST_L4SEL:  a_w[2] = l3s_q + IW'(IP_PROTO_POS);
         ST_PSEUDO: begin
            a_w[0] = psd_addr;
            a_w[1] = psd_addr + IW'(1);
         end
         ST_L4SUM: begin
            a_w[0] = ptr_q;
            a_w[1] = ptr_q + IW'(1);
         end
         ST_SEND:   a_w[0] = ptr_q;
         default: ;
      endcase
      for (int i = 0; i < NRP; i++) rd_addr[i] = a_w[i][AW-1:0];
   end

   // accumulator feed
   always_comb begin
      acc_load = 1'b0;
      acc_init = '0;
      acc_add  = 1'b0;
      acc_word = rd_word;
      case (state_q)
         ST_DECODE: acc_load = 1'b1;
         ST_IPSUM: begin
            acc_add = (ptr_q < ip_end);
            if (ptr_q == l3s_q + IW'(IP_CSUM_POS)) acc_word = '0;
         end
         ST_L4SEL: begin
            acc_load = 1'b1;
            acc_init = oc_add({8'h00, rd_d[2]}, 16'(l4len));
         end
         ST_PSEUDO: acc_add = 1'b1;
         ST_L4SUM: begin
            acc_add = (ptr_q < len_i);
            if (ptr_q == ck_addr) begin
               acc_word = '0;
            end else if (ptr_q + IW'(1) >= len_i) begin
               acc_word[7:0] = '0;
            end
         end
         default: ;
      endcase
   end

   // in-place field updates
   always_comb begin
      ww_en     = 1'b0;
      ww_addr_w = '0;
      ww_data   = '0;
      case (state_q)
         ST_IPWR: begin
            ww_en     = 1'b1;
            ww_addr_w = l3s_q + IW'(IP_CSUM_POS);
            ww_data   = ip_res;
         end
         ST_ZERO: begin
            ww_en     = 1'b1;
            ww_addr_w = l4s_q + IW'(UDP_CSUM_POS);
         end
         ST_L4WR: begin
            ww_en     = 1'b1;
            ww_addr_w = ck_addr;
            ww_data   = l4_res;
         end
         default: ;
      endcase
   end

   tcb_frame_store #(
      .DEPTH (MAX_LEN),
      .AW    (AW),
      .NRP   (NRP)
   ) store_i (
      .clk     (clk),
      .bw_en   (ld_en && (state_q == ST_IDLE)),
      .bw_addr (ld_addr),
      .bw_data (ld_data),
      .ww_en   (ww_en),
      .ww_addr (ww_addr_w[AW-1:0]),
      .ww_data (ww_data),
      .rd_addr (rd_addr),
      .rd_data (rd_d)
   );

   tcb_csum_acc acc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (acc_load),
      .load_val (acc_init),
      .add      (acc_add),
      .word     (acc_word),
      .acc      (acc)
   );

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         len_q     <= '0;
         fl_ip_q   <= 1'b0;
         fl_udp_q  <= 1'b0;
         fl_l4ck_q <= 1'b0;
         fl_l4_q   <= 1'b0;
         l3s_q     <= '0;
         l4s_q     <= '0;
         ptr_q     <= '0;
         k_q       <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               out_valid <= 1'b0;
               out_last  <= 1'b0;
               if (start) begin
                  len_q   <= frame_len;
                  state_q <= ST_DECODE;
               end
            end
            ST_DECODE: begin
               fl_ip_q   <= rd_d[0][FL_IPV4];
               fl_udp_q  <= rd_d[0][FL_UDP];
               fl_l4ck_q <= rd_d[0][FL_L4CK];
               fl_l4_q   <= rd_d[0][FL_L4];
               l3s_q     <= IW'(CB_BYTES) + IW'(rd_d[1]);
               l4s_q     <= IW'(CB_BYTES) + IW'(rd_d[1]) + IW'(rd_d[2]);
               ptr_q     <= IW'(CB_BYTES) + IW'(rd_d[1]);
               if (len_i <= IW'(CB_BYTES)) begin
                  state_q <= ST_IDLE;
               end else if (rd_d[0][FL_IPV4] && rd_d[0][FL_IPCK]) begin
                  state_q <= ST_IPSUM;
               end else begin
                  state_q <= ST_L4SEL;
               end
            end
            ST_IPSUM: begin
               if (ptr_q >= ip_end) state_q <= ST_IPWR;
               else                 ptr_q   <= ptr_q + IW'(2);
            end
            ST_IPWR: state_q <= ST_L4SEL;
            ST_L4SEL: begin
               ptr_q <= IW'(CB_BYTES);
               if (fl_ip_q && fl_l4_q && fl_udp_q && !fl_l4ck_q) begin
                  state_q <= ST_ZERO;
               end else if (fl_ip_q && fl_l4_q && fl_l4ck_q) begin
                  state_q <= ST_PSEUDO;
                  ptr_q   <= l4s_q;
                  k_q     <= '0;
               end else begin
                  state_q <= ST_SEND;
               end
            end
            ST_ZERO: state_q <= ST_SEND;
            ST_PSEUDO: begin
               k_q <= k_q + 2'd1;
               if (k_q == 2'd3) state_q <= ST_L4SUM;
            end
            ST_L4SUM: begin
               if (ptr_q >= len_i) begin
                  state_q <= ST_L4WR;
               end else begin
                  ptr_q <= ptr_q + IW'(2);
               end
            end
            ST_L4WR: begin
               ptr_q   <= IW'(CB_BYTES);
               state_q <= ST_SEND;
            end
            ST_SEND: begin
               out_valid <= 1'b1;
               out_data  <= rd_d[0];
               out_last  <= (ptr_q == last_idx);
               ptr_q     <= ptr_q + IW'(1);
               if (ptr_q == last_idx) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tcb_offload_chk.sv
module tcb_offload_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic out_valid,
   input logic out_last
);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !out_valid);

   // R2
   last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R2
   stream_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   // R2
   last_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> !busy);

   // R10
   valid_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(busy));

endmodule

bind tcb_offload_top tcb_offload_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .out_valid (out_valid),
   .out_last  (out_last)
);

// File: tb/tcb_offload_top_tb_top.sv
module tcb_offload_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_en = 1'b0;
   logic [7:0] ld_addr = '0;
   logic [7:0] ld_data = '0;
   logic       start = 1'b0;
   logic [8:0] frame_len = '0;
   logic       busy, out_valid, out_last;
   logic [7:0] out_data;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   int   exp_s = -1000;
   int   exp_n = 0;
   int   idx;
   bit   done = 1'b0;
   string tag = "R1";
   logic [7:0] fr [256];
   logic [7:0] em [256];
   logic [7:0] eb [256];

   tcb_offload_top dut_i (
      .clk (clk), .rst_n (rst_n), .ld_en (ld_en), .ld_addr (ld_addr),
      .ld_data (ld_data), .start (start), .frame_len (frame_len),
      .busy (busy), .out_valid (out_valid), .out_data (out_data),
      .out_last (out_last)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // per-cycle comparison against the expected stream (R2, R10)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (cyc >= exp_s && cyc < exp_s + exp_n) begin
            idx = cyc - exp_s;
            if (out_valid !== 1'b1 || out_data !== eb[idx] || out_last !== (idx == exp_n - 1)) begin
               errors++;
               $display("FAIL %s/R10 byte %0d cyc %0d: got v=%0b d=%02h l=%0b, expected v=1 d=%02h l=%0b",
                        tag, idx, cyc, out_valid, out_data, out_last, eb[idx], (idx == exp_n - 1));
            end
         end else if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s/R10 cyc %0d: got v=%0b, expected v=0", tag, cyc, out_valid);
         end
      end
   end

   always @(posedge clk) begin
      if (cyc == 150000 && !done) begin
         errors++;
         $display("FAIL watchdog (all requirements): got hang, expected end of run");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic int fold(input int s);
      int v = s;
      while ((v >> 16) != 0) v = (v & 16'hFFFF) + (v >> 16);
      return v;
   endfunction

   // transport sum over pseudo-header and segment, field counted as zero (R7, R9)
   function automatic int l4_raw(input int len);
      int l3, l4, off, s, lo;
      l3  = 8 + em[3];
      l4  = l3 + em[2];
      off = em[0][6] ? 6 : 16;
      s   = em[l3 + 9] + (len - l4);
      for (int i = 0; i < 4; i++) s += {em[l3 + 12 + 2*i], em[l3 + 13 + 2*i]};
      for (int p = l4; p < len; p += 2) begin
         if (p != l4 + off) begin
            lo = (p + 1 < len) ? em[p + 1] : 0;
            s += (em[p] << 8) + lo;
         end
      end
      return fold(s);
   endfunction

   task automatic compute(input int len, output int d, output int n);
      logic [7:0] fl;
      int l3, l4, ihl, s, cs, off;
      for (int i = 0; i < 256; i++) em[i] = fr[i];
      d  = 3;
      n  = (len > 8) ? len - 8 : 0;
      fl = em[0];
      l3 = 8 + em[3];
      l4 = l3 + em[2];
      if (len > 8) begin
         if (fl[7] && fl[5]) begin
            ihl = em[l3] & 15;
            s = 0;
            for (int p = l3; p < l3 + 4*ihl; p += 2)
               if (p != l3 + 10) s += {em[p], em[p + 1]};
            cs = (~fold(s)) & 16'hFFFF;
            em[l3 + 10] = 8'(cs >> 8);
            em[l3 + 11] = 8'(cs);
            d += 2*ihl + 2;
         end
         if (fl[7] && fl[3]) begin
            if (fl[6] && !fl[4]) begin
               em[l4 + 6] = 8'h00;
               em[l4 + 7] = 8'h00;
               d += 1;
            end else if (fl[4]) begin
               cs  = (~l4_raw(len)) & 16'hFFFF;
               if (fl[6] && cs == 0) cs = 16'hFFFF;
               off = fl[6] ? 6 : 16;
               em[l4 + off]     = 8'(cs >> 8);
               em[l4 + off + 1] = 8'(cs);
               d += (len - l4 + 1) / 2 + 6;
            end
         end
      end
      for (int i = 0; i < n; i++) eb[i] = em[i + 8];
   endtask

   task automatic mk(input int len, input int seed, input logic [7:0] flags,
                     input int l3off, input int l4off, input int ihl);
      for (int i = 0; i < 256; i++) fr[i] = 8'((i * 37 + seed) & 255);
      fr[0] = flags;
      fr[2] = 8'(l4off);
      fr[3] = 8'(l3off);
      if (8 + l3off + 9 < len) begin
         fr[8 + l3off]     = 8'(8'h40 | ihl);
         fr[8 + l3off + 9] = flags[6] ? 8'd17 : 8'd6;
      end
   endtask

   task automatic run_frame(input int len, input bit interfere);
      int d, n;
      while (busy) @(negedge clk);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_addr = 8'(i); ld_data = fr[i];
      end
      @(negedge clk);
      ld_en = 1'b0;
      compute(len, d, n);
      @(negedge clk);
      frame_len = 9'(len);
      start = 1'b1;
      exp_s = cyc + 1 + d;
      exp_n = n;
      @(negedge clk);
      start = 1'b0;
      if (interfere) begin
         // R11: load and restart attempts while the frame is being sent
         while (cyc < exp_s + 1) @(negedge clk);
         ld_en = 1'b1; ld_addr = 8'(len - 1); ld_data = ~fr[len - 1]; start = 1'b1;
         @(negedge clk);
         ld_en = 1'b0; start = 1'b0;
      end
      repeat (d + n + 4) @(negedge clk);
      checks++;
      if (busy !== 1'b0) begin
         errors++;
         $display("FAIL %s busy after frame: got %0b, expected 0", tag, busy);
      end
   endtask

   initial begin
      int s, x, l4;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (busy !== 1'b0 || out_valid !== 1'b0 || out_last !== 1'b0) begin
         errors++;
         $display("FAIL R1 in reset: got busy=%0b v=%0b l=%0b, expected 0 0 0", busy, out_valid, out_last);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (busy !== 1'b0 || out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 after reset: got busy=%0b v=%0b, expected 0 0", busy, out_valid);
      end

      tag = "R2";  mk(20, 3, 8'h00, 0, 20, 5);       run_frame(20, 0);
      tag = "R4";  mk(40, 5, 8'hA0, 0, 20, 5);       run_frame(40, 0);
      tag = "R4";  mk(44, 9, 8'hA0, 2, 24, 6);
      fr[8 + 2 + 10] = 8'h5A; fr[8 + 2 + 11] = 8'hC3; run_frame(44, 0);
      tag = "R6";  mk(50, 11, 8'hC8, 0, 20, 5);      run_frame(50, 0);
      tag = "R7";  mk(60, 13, 8'h98, 0, 20, 5);      run_frame(60, 0);
      tag = "R9";  mk(47, 17, 8'hD8, 0, 20, 5);      run_frame(47, 0);
      tag = "R8";  mk(48, 19, 8'hD8, 0, 20, 5);
      fr[28 + 8] = 8'h00; fr[28 + 9] = 8'h00;
      for (int i = 0; i < 256; i++) em[i] = fr[i];
      s = l4_raw(48);
      x = 16'hFFFF - s;
      l4 = 28;
      fr[l4 + 8] = 8'(x >> 8); fr[l4 + 9] = 8'(x);
      run_frame(48, 0);
      tag = "R5";  mk(52, 23, 8'h78, 0, 20, 5);      run_frame(52, 0);
      tag = "R3";  mk(8, 29, 8'hA0, 0, 20, 5);       run_frame(8, 0);
      tag = "R3";  mk(5, 31, 8'h00, 0, 20, 5);       run_frame(5, 0);
      tag = "R11"; mk(61, 37, 8'hF8, 1, 20, 5);      run_frame(61, 1);
      tag = "R2";  mk(9, 41, 8'h00, 0, 20, 5);       run_frame(9, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule